// File: doc/BRIEF.md
# ISA Slave Address and PROM Decoder

This block turns the raw host-side ISA signals into the select and enable lines a network peripheral needs while it is a bus slave. It watches the system address, the address-enable line and the four read/write strobes. From them it produces register read and write enables for a 32-byte I/O window, chip selects for a small address PROM and a larger boot PROM, the 16-bit I/O indication, the drive enable and data for the low byte of the data bus, and the channel-ready line.

The I/O window can sit at one of sixteen 32-byte aligned locations starting at 0x200. The boot PROM occupies an aligned block of 8K to 64K in the 1 MB memory space. The chip selects and the 16-bit indication are pure combinational decodes. Only the ready line and the buffered PROM byte involve clocked state. While reset is held, every select is deasserted and ready is high.

Top module: `isa_slave_decoder`

## Requirements
- R1: A register read (`reg_rd_o`) or write (`reg_wr_o`) is produced only while `aen_i` is low, the matching strobe (`ior_ni`/`iow_ni`, active low) is low and SA[9:0] lies in the I/O window. `reg_off_o` carries SA[4:0].
- R2: The I/O window spans 32 bytes starting at 0x200 + 32 × `io_base_sel_i`. An address outside it gives no register enable, no address PROM select and no 16-bit indication.
- R3: `iocs16_no` goes low whenever `aen_i` is low, `cfg_io16_i` is 1 and SA[9:0] is inside the window, whatever the strobes are. With `cfg_io16_i` at 0 it stays high.
- R4: With `cfg_apcs_en_i` set, a valid I/O read at window offsets 0 to 15 drives `apcs_no` low instead of `reg_rd_o`, and a write there produces no register write. With `cfg_apcs_en_i` clear, these offsets behave as registers and `apcs_no` stays high.
- R5: `bpcs_no` goes low only when `boot_en_i` is 1, `memr_ni` is low, `ref_ni` is high and the address is inside the boot block.
- R6: `boot_size_i` 0/1/2/3 selects a block of 8K/16K/32K/64K. The block starts at (`boot_base_i` with its low `boot_size_i` bits cleared) × 8K.
- R7: `sd_lo_oe_o` is high exactly while either PROM select is low. At every clock edge during such a read, `sd_lo_o` takes the value of `prom_d_i`.
- R8: Reads are qualified reads: a valid I/O read of a register or of the address PROM, or a boot PROM read. `iochrdy_o` goes low in the same cycle a qualified read begins and returns high after RDY_WAIT (default 3) clock edges with the read held. It is high whenever no qualified read is active, so writes never pull it low.
- R9: While `rst_ni` is low, all enables are 0, all selects are high, `sd_lo_oe_o` is 0 and `iochrdy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sa_i | input | 20 | System address |
| aen_i | input | 1 | Address enable, high during DMA cycles |
| ior_ni | input | 1 | I/O read strobe, active low |
| iow_ni | input | 1 | I/O write strobe, active low |
| memr_ni | input | 1 | Memory read strobe, active low |
| ref_ni | input | 1 | Refresh in progress, active low |
| io_base_sel_i | input | 4 | I/O window location select |
| boot_base_i | input | 7 | Boot block base, SA[19:13] |
| boot_size_i | input | 2 | Boot block size code |
| boot_en_i | input | 1 | Boot PROM decode enable |
| cfg_io16_i | input | 1 | Allow 16-bit I/O indication |
| cfg_apcs_en_i | input | 1 | Map window offsets 0-15 to the address PROM |
| prom_d_i | input | 8 | PROM private data bus |
| reg_rd_o | output | 1 | Register read enable |
| reg_wr_o | output | 1 | Register write enable |
| reg_off_o | output | 5 | Register offset in window |
| iocs16_no | output | 1 | 16-bit I/O indication, active low |
| apcs_no | output | 1 | Address PROM select, active low |
| bpcs_no | output | 1 | Boot PROM select, active low |
| sd_lo_oe_o | output | 1 | Drive enable for SD[7:0] |
| sd_lo_o | output | 8 | Buffered PROM byte for SD[7:0] |
| iochrdy_o | output | 1 | Channel ready |

## Verification
The bench targets window edges: the first and last byte of the window and the bytes just outside it, the top window location, and offsets 15 and 16 at the boundary of the address PROM region. A design with an off-by-one compare would claim a neighbour's byte or lose its own. Boot blocks of every size are probed with unaligned base values and with refresh active. A design that compares the wrong number of base bits, or that ignores refresh, would select the PROM during a refresh or outside its block. The ready line is sampled on each clock of a held read. A wrong wait count shows up as ready returning a cycle early or late, and a design that let writes stall the bus is caught as well.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;
  localparam int unsigned SYS_ADDR_W  = 20;
  localparam int unsigned IO_DEC_W    = 10;
  localparam int unsigned BOOT_GRAN_L = 13;

  function automatic logic [6:0] size_mask(input logic [1:0] code);
    logic [6:0] m;
    m = 7'h7f;
    for (int i = 0; i < 4; i++) begin
      if (i < int'(code)) m[i] = 1'b0;
    end
    return m;
  endfunction
endpackage

// File: rtl/io_win_dec.sv
module io_win_dec #(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned WIN_BYTES = 32,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned ORIGIN    = 'h200,
  parameter int unsigned PROM_SPAN = 16,
  localparam int unsigned OFF_W    = $clog2(WIN_BYTES),
  localparam int unsigned SLOT_W   = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              aen_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              prom_en_i,
  output logic              hit_o,
  output logic              in_prom_o,
  output logic [OFF_W-1:0]  off_o
);
  localparam logic [SLOT_W-1:0] SLOT_BASE = SLOT_W'(ORIGIN >> OFF_W);

  logic [SLOT_W-1:0] slot;

  assign slot      = SLOT_BASE + SLOT_W'(sel_i);
  assign hit_o     = !aen_i && (addr_i[ADDR_W-1:OFF_W] == slot);
  assign off_o     = addr_i[OFF_W-1:0];
  assign in_prom_o = prom_en_i && (off_o < OFF_W'(PROM_SPAN));
endmodule

// File: rtl/boot_win_dec.sv
module boot_win_dec
  import isa_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned GRAN_L = 13,
  localparam int unsigned FLD_W = ADDR_W - GRAN_L
) (
  input  logic [FLD_W-1:0] fld_i,
  input  logic [FLD_W-1:0] base_i,
  input  logic [1:0]       size_i,
  input  logic             en_i,
  input  logic             memr_ni,
  input  logic             ref_ni,
  output logic             sel_o
);
  logic [FLD_W-1:0] mask;
  logic             in_blk;

  assign mask   = FLD_W'(size_mask(size_i));
  assign in_blk = ((fld_i ^ base_i) & mask) == '0;
  assign sel_o  = en_i && !memr_ni && ref_ni && in_blk;
endmodule

// File: rtl/rd_path.sv
module rd_path #(
  parameter int unsigned RDY_WAIT = 3,
  parameter int unsigned DATA_W   = 8,
  localparam int unsigned CNT_W   = $clog2(RDY_WAIT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_act_i,
  input  logic              prom_rd_i,
  input  logic [DATA_W-1:0] prom_d_i,
  output logic              iochrdy_o,
  output logic [DATA_W-1:0] sd_lo_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             done;

  assign done      = cnt_q >= CNT_W'(RDY_WAIT);
  assign iochrdy_o = !(rd_act_i && !done);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!rd_act_i)   cnt_q <= '0;
    else if (!done)       cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sd_lo_o <= '0;
    else if (prom_rd_i) sd_lo_o <= prom_d_i;
  end

  AST_RDY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_act_i) |-> !iochrdy_o); // R8
  AST_RDY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act_i && $past(rd_act_i) && $past(iochrdy_o)) |-> iochrdy_o); // R8
endmodule

// File: rtl/isa_slave_decoder.sv
module isa_slave_decoder
  import isa_dec_pkg::*;
#(
  parameter int unsigned IO_WIN    = 32,
  parameter int unsigned IO_SEL_W  = 4,
  parameter int unsigned IO_ORIGIN = 'h200,
  parameter int unsigned PROM_SPAN = 16,
  parameter int unsigned RDY_WAIT  = 3,
  parameter int unsigned DATA_W    = 8,
  localparam int unsigned OFF_W    = $clog2(IO_WIN),
  localparam int unsigned BFLD_W   = SYS_ADDR_W - BOOT_GRAN_L
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [SYS_ADDR_W-1:0] sa_i,
  input  logic                 aen_i,
  input  logic                 ior_ni,
  input  logic                 iow_ni,
  input  logic                 memr_ni,
  input  logic                 ref_ni,
  input  logic [IO_SEL_W-1:0]  io_base_sel_i,
  input  logic [BFLD_W-1:0]    boot_base_i,
  input  logic [1:0]           boot_size_i,
  input  logic                 boot_en_i,
  input  logic                 cfg_io16_i,
  input  logic                 cfg_apcs_en_i,
  input  logic [DATA_W-1:0]    prom_d_i,
  output logic                 reg_rd_o,
  output logic                 reg_wr_o,
  output logic [OFF_W-1:0]     reg_off_o,
  output logic                 iocs16_no,
  output logic                 apcs_no,
  output logic                 bpcs_no,
  output logic                 sd_lo_oe_o,
  output logic [DATA_W-1:0]    sd_lo_o,
  output logic                 iochrdy_o
);
  logic io_hit, in_prom, boot_sel;
  logic io_rd, io_wr, ap_rd, rg_rd, rg_wr, prom_rd, rd_act, rdy;
  logic unused_addr;

  assign unused_addr = ^sa_i[BOOT_GRAN_L-1:IO_DEC_W];

  io_win_dec #(
    .ADDR_W(IO_DEC_W), .WIN_BYTES(IO_WIN), .SEL_W(IO_SEL_W),
    .ORIGIN(IO_ORIGIN), .PROM_SPAN(PROM_SPAN)
  ) u_io (
    .addr_i(sa_i[IO_DEC_W-1:0]), .aen_i(aen_i), .sel_i(io_base_sel_i),
    .prom_en_i(cfg_apcs_en_i), .hit_o(io_hit), .in_prom_o(in_prom),
    .off_o(reg_off_o)
  );

  boot_win_dec #(.ADDR_W(SYS_ADDR_W), .GRAN_L(BOOT_GRAN_L)) u_boot (
    .fld_i(sa_i[SYS_ADDR_W-1:BOOT_GRAN_L]), .base_i(boot_base_i),
    .size_i(boot_size_i), .en_i(boot_en_i), .memr_ni(memr_ni),
    .ref_ni(ref_ni), .sel_o(boot_sel)
  );

  assign io_rd   = io_hit && !ior_ni;
  assign io_wr   = io_hit && !iow_ni;
  assign ap_rd   = io_rd && in_prom;
  assign rg_rd   = io_rd && !in_prom;
  assign rg_wr   = io_wr && !in_prom;
  assign prom_rd = ap_rd || boot_sel;
  assign rd_act  = rst_ni && (io_rd || boot_sel);

  rd_path #(.RDY_WAIT(RDY_WAIT), .DATA_W(DATA_W)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_act_i(rd_act),
    .prom_rd_i(prom_rd), .prom_d_i(prom_d_i), .iochrdy_o(rdy),
    .sd_lo_o(sd_lo_o)
  );

  assign reg_rd_o   = rst_ni && rg_rd;
  assign reg_wr_o   = rst_ni && rg_wr;
  assign apcs_no    = !(rst_ni && ap_rd);
  assign bpcs_no    = !(rst_ni && boot_sel);
  assign iocs16_no  = !(rst_ni && cfg_io16_i && io_hit);
  assign sd_lo_oe_o = rst_ni && prom_rd;
  assign iochrdy_o  = !rst_ni || rdy;

  AST_AEN_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aen_i |-> (!reg_rd_o && !reg_wr_o && apcs_no && iocs16_no)); // R1
  AST_NARROW_IO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_io16_i |-> iocs16_no); // R3
  AST_APCS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_rd_o, !apcs_no})); // R4
  AST_BPCS_REFRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_ni |-> bpcs_no); // R5
  AST_IDLE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ior_ni && memr_ni) |-> iochrdy_o); // R8
endmodule

// File: tb/sim_isa_slave_decoder.sv
module sim_isa_slave_decoder;
  logic clk = 0, rst_ni = 0;
  logic [19:0] sa = 0;
  logic aen = 0, ior_n = 1, iow_n = 1, memr_n = 1, ref_n = 1;
  logic [3:0] sel = 0;
  logic [6:0] bbase = 0;
  logic [1:0] bsize = 0;
  logic ben = 0, io16 = 0, apen = 0;
  logic [7:0] pd = 0;
  logic rd, wr, io16_n, ap_n, bp_n, oe, rdy;
  logic [4:0] off;
  logic [7:0] sdl;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  isa_slave_decoder u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sa_i(sa), .aen_i(aen), .ior_ni(ior_n),
    .iow_ni(iow_n), .memr_ni(memr_n), .ref_ni(ref_n), .io_base_sel_i(sel),
    .boot_base_i(bbase), .boot_size_i(bsize), .boot_en_i(ben),
    .cfg_io16_i(io16), .cfg_apcs_en_i(apen), .prom_d_i(pd),
    .reg_rd_o(rd), .reg_wr_o(wr), .reg_off_o(off), .iocs16_no(io16_n),
    .apcs_no(ap_n), .bpcs_no(bp_n), .sd_lo_oe_o(oe), .sd_lo_o(sdl),
    .iochrdy_o(rdy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_io(input logic [19:0] a, input logic e, input logic [3:0] s);
    int lo = 'h200 + 32 * int'(s);
    return !e && int'(a[9:0]) >= lo && int'(a[9:0]) < lo + 32;
  endfunction

  function automatic bit m_boot(input logic [19:0] a, input logic [6:0] b, input logic [1:0] z);
    int span = 8192 << z;
    int st = (int'(b) >> z) * span;
    return int'(a) >= st && int'(a) < st + span;
  endfunction

  task automatic check_decode(input string tag);
    bit hit = m_io(sa, aen, sel);
    bit pr = apen && sa[4:0] < 16;
    bit e_ap = hit && !ior_n && pr;
    bit e_bp = ben && !memr_n && ref_n && m_boot(sa, bbase, bsize);
    chk({tag, " R1 reg_rd"}, 32'(rd), 32'(hit && !ior_n && !pr));
    chk({tag, " R4 reg_wr"}, 32'(wr), 32'(hit && !iow_n && !pr));
    if (hit) chk({tag, " R1 off"}, 32'(off), 32'(sa[4:0]));
    chk({tag, " R3 iocs16"}, 32'(io16_n), 32'(!(io16 && hit)));
    chk({tag, " R4 apcs"}, 32'(ap_n), 32'(!e_ap));
    chk({tag, " R5 bpcs"}, 32'(bp_n), 32'(!e_bp));
    chk({tag, " R7 oe"}, 32'(oe), 32'(e_ap || e_bp));
  endtask

  task automatic idle();
    @(negedge clk);
    ior_n = 1; iow_n = 1; memr_n = 1; ref_n = 1; aen = 0;
    @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R9: reset quiet while everything requests
    sel = 4'd3; sa = 20'h260; io16 = 1; ior_n = 0; iow_n = 0; apen = 1;
    ben = 1; memr_n = 0;
    #35;
    chk("R9 rd", 32'(rd), 0); chk("R9 wr", 32'(wr), 0);
    chk("R9 iocs16", 32'(io16_n), 1); chk("R9 apcs", 32'(ap_n), 1);
    chk("R9 bpcs", 32'(bp_n), 1); chk("R9 oe", 32'(oe), 0);
    chk("R9 rdy", 32'(rdy), 1);
    ior_n = 1; iow_n = 1; memr_n = 1; apen = 0; ben = 0;
    @(negedge clk); rst_ni = 1;
    idle();

    // R2: window edges at lowest and highest location
    foreach (sel[i]) ;
    for (int s = 0; s < 16; s += 15) begin
      @(negedge clk); sel = 4'(s); io16 = 1; apen = 0; iow_n = 1; ior_n = 0;
      sa = 20'('h200 + 32 * s);      #2; check_decode("R2 first"); chk("R2 first hit", 32'(rd), 1);
      sa = 20'('h200 + 32 * s + 31); #2; check_decode("R2 last");  chk("R2 last hit", 32'(rd), 1);
      sa = 20'('h200 + 32 * s - 1);  #2; check_decode("R2 below"); chk("R2 below miss", 32'(rd), 0);
      sa = 20'('h200 + 32 * s + 32); #2; check_decode("R2 above"); chk("R2 above miss", 32'(rd), 0);
    end
    idle();

    // R3: strobe-free 16-bit indication, and narrow mode
    @(negedge clk); sel = 4'd5; sa = 20'h2A7; io16 = 1; #2;
    chk("R3 no strobe", 32'(io16_n), 0);
    io16 = 0; #2; chk("R3 forced 8-bit", 32'(io16_n), 1);
    aen = 1; io16 = 1; #2; chk("R3 aen high", 32'(io16_n), 1);
    aen = 0;

    // R4: PROM region boundary
    @(negedge clk); apen = 1; ior_n = 0; sa = 20'h2AF; #2; check_decode("R4 off15");
    chk("R4 off15 apcs", 32'(ap_n), 0);
    sa = 20'h2B0; #2; check_decode("R4 off16"); chk("R4 off16 reg", 32'(rd), 1);
    ior_n = 1; iow_n = 0; sa = 20'h2A3; #2; chk("R4 write ignored", 32'(wr), 0);
    apen = 0; #2; chk("R4 write disabled map", 32'(wr), 1);
    idle();

    // R5/R6: boot blocks per size with unaligned base
    for (int z = 0; z < 4; z++) begin
      @(negedge clk); ben = 1; bsize = 2'(z); bbase = 7'h4B; memr_n = 0; ref_n = 1;
      sa = 20'(((32'h4B >> z) * (8192 << z)));            #2; check_decode("R6 start");
      chk("R6 start hit", 32'(bp_n), 0);
      sa = 20'(((32'h4B >> z) * (8192 << z)) + (8192 << z) - 1); #2; check_decode("R6 end");
      sa = 20'(((32'h4B >> z) * (8192 << z)) + (8192 << z));     #2; check_decode("R6 past");
      chk("R6 past miss", 32'(bp_n), 1);
      sa = 20'(((32'h4B >> z) * (8192 << z))); ref_n = 0; #2; chk("R5 refresh", 32'(bp_n), 1);
      ben = 0; ref_n = 1; #2; chk("R5 disabled", 32'(bp_n), 1);
    end
    idle();

    // R7: buffered PROM byte
    @(negedge clk); ben = 1; bsize = 0; bbase = 7'h60; sa = 20'hC0010; pd = 8'hA5; memr_n = 0;
    @(negedge clk); chk("R7 oe", 32'(oe), 1); chk("R7 data A5", 32'(sdl), 8'hA5);
    pd = 8'h3C;
    @(negedge clk); chk("R7 data 3C", 32'(sdl), 8'h3C);
    idle();

    // R8: ready timing on held read, then release
    @(negedge clk); sel = 4'd2; sa = 20'h248; apen = 0; ior_n = 0; #2;
    chk("R8 low at start", 32'(rdy), 0);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk); #2; chk($sformatf("R8 edge %0d", k), 32'(rdy), 32'(k >= 3));
    end
    ior_n = 1; #2; chk("R8 release", 32'(rdy), 1);
    idle();
    @(negedge clk); iow_n = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #2; chk("R8 write no wait", 32'(rdy), 1);
    end
    idle();

    // random mix
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      sel = 4'($urandom); io16 = 1'($urandom); apen = 1'($urandom);
      ben = 1'($urandom); bsize = 2'($urandom); bbase = 7'($urandom);
      sa = 20'($urandom);
      if ($urandom % 2) sa[9:0] = 10'('h200 + 32 * int'(sel) + int'($urandom % 32));
      if ($urandom % 3 == 0) sa[19:13] = bbase ^ 7'($urandom % 4);
      aen = ($urandom % 5 == 0); ior_n = 1'($urandom); iow_n = 1'($urandom);
      memr_n = 1'($urandom); ref_n = ($urandom % 4 != 0);
      #2; check_decode("rand");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule